// File: doc/BRIEF.md
# SPI radio configuration slave

This block is the host-facing command port of a small sub-GHz transceiver. An external controller drives an SPI bus in mode 0 (clock idles low, data sampled on the rising clock edge, most significant bit first). Each transaction starts when chip select falls and ends when it rises. The first byte of a transaction is a command and every following byte is data. While the command byte shifts in, the slave shifts out a status byte built from two input pins. The RF path, CRC generation and air timing are not part of this block.

The slave holds ten configuration registers, a transmit payload buffer, a transmit address buffer and a receive payload buffer. The radio side fills the receive buffer through a simple load port. Some commands carry operands in the command byte itself: the config read and write commands carry a start register in the low nibble, and the channel command carries power, band and the top channel bit. The current channel, power level and band are driven out as ports.

The SPI pins are sampled by the system clock, which must run at least eight times faster than SCK.

Top module: `radio_spi_slave`

## Requirements
- R1: The status byte is the first byte shifted out in every transaction. Its bit 7 is `addr_match` and its bit 5 is `data_ready`, both captured when chip select falls, and all its other bits are 0.
- R2: A command byte 0x0N with N from 0 to 9 writes the following data bytes into registers N, N+1 and so on. Bytes that would land past register 9 are dropped.
- R3: A command byte 0x1N with N from 0 to 9 returns registers N, N+1 and so on in the following bytes. Once past register 9 it returns 0x00.
- R4: A config command whose start nibble is above 9 writes no register and returns 0x00 for every data byte.
- R5: Unimplemented register bits always read as 0. The implemented bits are: register 1 bits 5:0, register 2 bits 6:4 and 2:0, registers 3 and 4 bits 5:0, and all bits of registers 0 and 5 to 9.
- R6: Command 0x20 writes and 0x21 reads the transmit payload. Each transaction starts at index 0 and wraps to 0 at the width held in register 4 bits 5:0. A width of 0, or a width above the 32-entry depth, means 32.
- R7: Command 0x22 writes and 0x23 reads the four-byte transmit address. Each transaction starts at index 0 and wraps after the fourth byte.
- R8: Command 0x24 reads the receive payload, which is filled by the load port. Reads start at index 0 and wrap at the width held in register 3 bits 5:0, with the same rule as R6.
- R9: A command byte 0x8X followed by a data byte D sets register 0 to D and register 1 bits 3:0 to X. Both update together when chip select rises, and register 1 bits 5:4 are kept. If no data byte follows, nothing changes.
- R10: Unknown command codes change no state. After the status byte they return 0x00, and so do the data bytes of every write command.
- R11: SCK edges while chip select is high are ignored, and a partial byte is discarded when chip select rises.
- R12: `channel` is {register 1 bit 0, register 0}, `pa_power` is register 1 bits 3:2 and `band_sel` is register 1 bit 1. All three are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI clock from the controller |
| csn | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller, 0 while deselected |
| addr_match | input | 1 | Radio flag reported in status bit 7 |
| data_ready | input | 1 | Radio flag reported in status bit 5 |
| rx_load_en | input | 1 | Write strobe for the receive payload buffer |
| rx_load_idx | input | 5 | Receive payload index to write |
| rx_load_data | input | 8 | Receive payload byte to write |
| channel | output | 9 | Current channel number |
| pa_power | output | 2 | Current power amplifier setting |
| band_sel | output | 1 | Current band select |

## Verification
Two things can happen in the same clock cycle: the radio side can write the receive payload through the load port while the serial side fetches the next receive byte for the shift register. The bench provokes this by strobing the load port every cycle, at an index outside the configured receive width, for the whole of a 0x24 read burst. The scoreboard must see the preloaded bytes wrap at the width, undisturbed. A wider read that follows must then return the value that was being written at the contested index.

// File: rtl/radio_spi_pkg.sv
package radio_spi_pkg;

   localparam int CFG_COUNT = 10;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_CFG_WR,
      OP_CFG_RD,
      OP_TXP_WR,
      OP_TXP_RD,
      OP_TXA_WR,
      OP_TXA_RD,
      OP_RXP_RD,
      OP_CHAN
   } op_e;

   // Decode a command byte into an operation; bad start addresses fold into OP_NONE.
   function automatic op_e decode_op(input logic [7:0] c);
      case (c[7:4])
         4'h0: return (int'(c[3:0]) < CFG_COUNT) ? OP_CFG_WR : OP_NONE;
         4'h1: return (int'(c[3:0]) < CFG_COUNT) ? OP_CFG_RD : OP_NONE;
         4'h8: return OP_CHAN;
         4'h2: begin
            case (c[3:0])
               4'h0: return OP_TXP_WR;
               4'h1: return OP_TXP_RD;
               4'h2: return OP_TXA_WR;
               4'h3: return OP_TXA_RD;
               4'h4: return OP_RXP_RD;
               default: return OP_NONE;
            endcase
         end
         default: return OP_NONE;
      endcase
   endfunction

   // Implemented bits of each configuration register.
   function automatic logic [7:0] cfg_mask(input int idx);
      case (idx)
         1, 3, 4: return 8'h3F;
         2:       return 8'h77;
         default: return 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/radio_spi_shifter.sv
module radio_spi_shifter #(
   parameter int BW = 8,
   localparam int CW = $clog2(BW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sck,
   input  logic          csn,
   input  logic          mosi,
   input  logic [BW-1:0] first_byte,
   input  logic [BW-1:0] next_byte,
   output logic          miso,
   output logic          active,
   output logic          cs_start,
   output logic          cs_end,
   output logic          byte_done,
   output logic [BW-1:0] rx_byte
);

   if (BW < 2 || (1 << CW) != BW) begin : g_bad_bw
      $error("radio_spi_shifter: BW must be a power of two of at least 2");
   end

   logic          sck_s, sck_q, csn_s, csn_q, mosi_s;
   logic [CW-1:0] bit_cnt;
   logic [BW-1:0] in_sh, out_sh;
   logic          sck_rise, sck_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_s  <= 1'b0;
         sck_q  <= 1'b0;
         csn_s  <= 1'b1;
         csn_q  <= 1'b1;
         mosi_s <= 1'b0;
      end else begin
         sck_s  <= sck;
         sck_q  <= sck_s;
         csn_s  <= csn;
         csn_q  <= csn_s;
         mosi_s <= mosi;
      end
   end

   assign active   = ~csn_s;
   assign cs_start = csn_q & ~csn_s;
   assign cs_end   = ~csn_q & csn_s;
   assign sck_rise = active & sck_s & ~sck_q;
   assign sck_fall = active & ~sck_s & sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         in_sh     <= '0;
         out_sh    <= '0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
      end else begin
         byte_done <= 1'b0;
         if (cs_start) begin
            out_sh  <= first_byte;
            bit_cnt <= '0;
         end else if (sck_rise) begin
            in_sh   <= {in_sh[BW-2:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CW'(BW - 1)) begin
               byte_done <= 1'b1;
               rx_byte   <= {in_sh[BW-2:0], mosi_s};
               bit_cnt   <= '0;
            end
         end else if (sck_fall) begin
            if (bit_cnt == '0) out_sh <= next_byte;
            else               out_sh <= {out_sh[BW-2:0], 1'b0};
         end
      end
   end

   assign miso = active & out_sh[BW-1];

   // R1: a completed byte always leaves the bit counter at a byte boundary
   assert_byte_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> (bit_cnt == '0));

endmodule

// File: rtl/radio_byte_buf.sv
module radio_byte_buf #(
   parameter int DEPTH = 32,
   parameter bit CLEAR = 1'b1,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("radio_byte_buf: DEPTH must be at least 2");
   end

   logic [7:0] mem [DEPTH];

   if (CLEAR) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we && int'(waddr) < DEPTH) begin
            mem[waddr] <= wdata;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (we && int'(waddr) < DEPTH) mem[waddr] <= wdata;
      end
   end

   assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;

endmodule

// File: rtl/radio_cfg_regs.sv
module radio_cfg_regs
   import radio_spi_pkg::*;
#(
   parameter int N  = CFG_COUNT,
   parameter int AW = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [AW-1:0]       waddr,
   input  logic [7:0]          wdata,
   input  logic                chan_apply,
   input  logic [7:0]          chan_lo,
   input  logic [3:0]          chan_hi,
   input  logic [AW-1:0]       raddr,
   output logic [7:0]          rdata,
   output logic [N-1:0][7:0]   cfg_q
);

   if (N < 2 || N > (1 << AW)) begin : g_bad_count
      $error("radio_cfg_regs: N must fit the address width and hold registers 0 and 1");
   end

   logic [7:0] regs [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) regs[i] <= '0;
      end else if (chan_apply) begin
         regs[0]      <= chan_lo;
         regs[1][3:0] <= chan_hi;
      end else if (we) begin
         for (int i = 0; i < N; i++) begin
            if (waddr == AW'(i)) regs[i] <= wdata & cfg_mask(i);
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_flat
      assign cfg_q[g] = regs[g];
   end

   assign rdata = (int'(raddr) < N) ? regs[raddr] : 8'h00;

   // R9: the channel update lands only at deselect, never alongside a serial write
   assert_apply_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(chan_apply && we));

   // R5: unimplemented bits never read back as 1
   assert_reserved_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(raddr) < N) |-> ((rdata & ~cfg_mask(int'(raddr))) == 8'h00));

endmodule

// File: rtl/radio_spi_slave.sv
module radio_spi_slave
   import radio_spi_pkg::*;
#(
   parameter int PAYLOAD_DEPTH = 32,
   parameter int ADDR_BYTES    = 4,
   parameter bit CLEAR_BUFFERS = 1'b1,
   localparam int PIW = $clog2(PAYLOAD_DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sck,
   input  logic           csn,
   input  logic           mosi,
   output logic           miso,
   input  logic           addr_match,
   input  logic           data_ready,
   input  logic           rx_load_en,
   input  logic [PIW-1:0] rx_load_idx,
   input  logic [7:0]     rx_load_data,
   output logic [8:0]     channel,
   output logic [1:0]     pa_power,
   output logic           band_sel
);

   localparam int LW  = PIW + 1;
   localparam int TAW = $clog2(ADDR_BYTES);
   localparam int PW  = 4;

   if (PAYLOAD_DEPTH < 2 || PAYLOAD_DEPTH > 63) begin : g_bad_depth
      $error("radio_spi_slave: PAYLOAD_DEPTH must lie in 2..63");
   end
   if (ADDR_BYTES < 2 || ADDR_BYTES > 8 || ADDR_BYTES > PAYLOAD_DEPTH) begin : g_bad_addr
      $error("radio_spi_slave: ADDR_BYTES must lie in 2..8");
   end

   logic                       active, cs_start, cs_end, byte_done;
   logic [7:0]                 rx_byte, status_byte, next_byte;
   op_e                        op_q;
   logic                       have_cmd;
   logic [3:0]                 cmd_lo_q;
   logic [PW-1:0]              ptr_q;
   logic [PIW-1:0]             idx_q, idx_nxt;
   logic [LW-1:0]              lim, idx_inc;
   logic [7:0]                 chan_lo_q;
   logic                       chan_pend_q;
   logic                       data_byte, cfg_we, txp_we, txa_we, chan_apply;
   logic [7:0]                 cfg_rd, txp_rd, txa_rd, rxp_rd;
   logic [CFG_COUNT-1:0][7:0]  cfg_q;

   assign status_byte = {addr_match, 1'b0, data_ready, 5'b0};

   radio_spi_shifter #(.BW(8)) u_shift (
      .clk, .rst_n, .sck, .csn, .mosi,
      .first_byte (status_byte),
      .next_byte  (next_byte),
      .miso, .active, .cs_start, .cs_end, .byte_done, .rx_byte
   );

   function automatic logic [LW-1:0] span(input logic [7:0] w);
      if (w[5:0] == 6'd0 || int'(w[5:0]) > PAYLOAD_DEPTH) return LW'(PAYLOAD_DEPTH);
      return LW'(w[5:0]);
   endfunction

   always_comb begin
      case (op_q)
         OP_TXP_WR, OP_TXP_RD: lim = span(cfg_q[4]);
         OP_RXP_RD:            lim = span(cfg_q[3]);
         OP_TXA_WR, OP_TXA_RD: lim = LW'(ADDR_BYTES);
         default:              lim = LW'(PAYLOAD_DEPTH);
      endcase
   end

   assign idx_inc = {1'b0, idx_q} + 1'b1;
   assign idx_nxt = (idx_inc >= lim) ? '0 : idx_inc[PIW-1:0];

   assign data_byte  = byte_done & have_cmd & active;
   assign cfg_we     = data_byte & (op_q == OP_CFG_WR) & (int'(ptr_q) < CFG_COUNT);
   assign txp_we     = data_byte & (op_q == OP_TXP_WR);
   assign txa_we     = data_byte & (op_q == OP_TXA_WR);
   assign chan_apply = cs_end & have_cmd & (op_q == OP_CHAN) & chan_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q        <= OP_NONE;
         have_cmd    <= 1'b0;
         cmd_lo_q    <= '0;
         ptr_q       <= '0;
         idx_q       <= '0;
         chan_lo_q   <= '0;
         chan_pend_q <= 1'b0;
      end else if (cs_start) begin
         op_q        <= OP_NONE;
         have_cmd    <= 1'b0;
         chan_pend_q <= 1'b0;
      end else if (byte_done && active) begin
         if (!have_cmd) begin
            op_q     <= decode_op(rx_byte);
            have_cmd <= 1'b1;
            cmd_lo_q <= rx_byte[3:0];
            ptr_q    <= rx_byte[3:0];
            idx_q    <= '0;
         end else begin
            case (op_q)
               OP_CFG_WR, OP_CFG_RD: begin
                  if (int'(ptr_q) < CFG_COUNT) ptr_q <= ptr_q + 1'b1;
               end
               OP_TXP_WR, OP_TXP_RD, OP_TXA_WR, OP_TXA_RD, OP_RXP_RD: idx_q <= idx_nxt;
               OP_CHAN: begin
                  if (!chan_pend_q) begin
                     chan_lo_q   <= rx_byte;
                     chan_pend_q <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   radio_cfg_regs #(.N(CFG_COUNT), .AW(PW)) u_cfg (
      .clk, .rst_n,
      .we         (cfg_we),
      .waddr      (ptr_q),
      .wdata      (rx_byte),
      .chan_apply (chan_apply),
      .chan_lo    (chan_lo_q),
      .chan_hi    (cmd_lo_q),
      .raddr      (ptr_q),
      .rdata      (cfg_rd),
      .cfg_q      (cfg_q)
   );

   radio_byte_buf #(.DEPTH(PAYLOAD_DEPTH), .CLEAR(CLEAR_BUFFERS)) u_txp (
      .clk, .rst_n,
      .we (txp_we), .waddr (idx_q), .wdata (rx_byte),
      .raddr (idx_q), .rdata (txp_rd)
   );

   radio_byte_buf #(.DEPTH(ADDR_BYTES), .CLEAR(CLEAR_BUFFERS)) u_txa (
      .clk, .rst_n,
      .we (txa_we), .waddr (idx_q[TAW-1:0]), .wdata (rx_byte),
      .raddr (idx_q[TAW-1:0]), .rdata (txa_rd)
   );

   radio_byte_buf #(.DEPTH(PAYLOAD_DEPTH), .CLEAR(CLEAR_BUFFERS)) u_rxp (
      .clk, .rst_n,
      .we (rx_load_en), .waddr (rx_load_idx), .wdata (rx_load_data),
      .raddr (idx_q), .rdata (rxp_rd)
   );

   always_comb begin
      case (op_q)
         OP_CFG_RD: next_byte = cfg_rd;
         OP_TXP_RD: next_byte = txp_rd;
         OP_TXA_RD: next_byte = txa_rd;
         OP_RXP_RD: next_byte = rxp_rd;
         default:   next_byte = 8'h00;
      endcase
   end

   assign channel  = {cfg_q[1][0], cfg_q[0]};
   assign pa_power = cfg_q[1][3:2];
   assign band_sel = cfg_q[1][1];

   // R1: status bit 7 leads the transaction on the serial output
   assert_status_lead_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_start |=> (miso == $past(addr_match)));

   // R11: with chip select high the configuration does not move
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !cs_end) |=> $stable(cfg_q));

   // R6: buffer index stays inside the active window when a data byte lands
   assert_index_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_byte && (op_q inside {OP_TXP_WR, OP_TXP_RD, OP_TXA_WR, OP_TXA_RD, OP_RXP_RD}))
      |-> ({1'b0, idx_q} < lim));

endmodule

// File: tb/test_radio_spi_slave.sv
module test_radio_spi_slave;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       sck = 1'b0, csn = 1'b1, mosi = 1'b0;
   logic       addr_match = 1'b0, data_ready = 1'b0;
   logic       rx_load_en = 1'b0;
   logic [4:0] rx_load_idx = '0;
   logic [7:0] rx_load_data = '0;
   logic       miso;
   logic [8:0] channel;
   logic [1:0] pa_power;
   logic       band_sel;

   always #2 clk = ~clk;

   radio_spi_slave i_radio_spi_slave (
      .clk, .rst_n, .sck, .csn, .mosi, .miso,
      .addr_match, .data_ready,
      .rx_load_en, .rx_load_idx, .rx_load_data,
      .channel, .pa_power, .band_sel
   );

   int         n_vec = 0, n_bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] mq[$], eq[$];
   int         nbit = 0;
   logic [7:0] shreg = '0, e_b;
   string      t_b;
   bit         hammer_stop;

   // Monitor: assemble each byte seen on miso and compare with the scoreboard
   always @(posedge sck or posedge csn) begin
      if (csn) nbit = 0;
      else begin
         shreg = {shreg[6:0], miso};
         nbit++;
         if (nbit == 8) begin
            nbit = 0;
            n_vec++;
            if (exp_q.size() == 0) begin
               n_bad++;
               $display("FAIL R1: unexpected byte, got %h expected none", shreg);
            end else begin
               e_b = exp_q.pop_front();
               t_b = tag_q.pop_front();
               if (shreg !== e_b) begin
                  n_bad++;
                  $display("FAIL %s: miso byte got %h expected %h", t_b, shreg, e_b);
               end
            end
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] st();
      return {addr_match, 1'b0, data_ready, 5'b0};
   endfunction

   task automatic half();
      repeat (4) @(negedge clk);
   endtask

   task automatic put(input logic [7:0] m, input logic [7:0] e);
      mq.push_back(m);
      eq.push_back(e);
   endtask

   task automatic spi_txn(input string tag, input bit keep_cs = 1'b0);
      foreach (eq[i]) begin
         exp_q.push_back(eq[i]);
         tag_q.push_back(tag);
      end
      @(negedge clk);
      csn = 1'b0;
      half();
      for (int i = 0; i < mq.size(); i++) begin
         for (int b = 7; b >= 0; b--) begin
            mosi = mq[i][b];
            half();
            sck = 1'b1;
            half();
            sck = 1'b0;
         end
      end
      half();
      if (!keep_cs) begin
         csn = 1'b1;
         repeat (8) @(negedge clk);
      end
      mq.delete();
      eq.delete();
   endtask

   task automatic rx_load(input int idx, input logic [7:0] d);
      @(negedge clk);
      rx_load_en   = 1'b1;
      rx_load_idx  = 5'(idx);
      rx_load_data = d;
      @(negedge clk);
      rx_load_en   = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R12 reset state, R1 idle output
      chk("R12 channel", 32'(channel), 32'h0);
      chk("R12 pa_power", 32'(pa_power), 32'h0);
      chk("R12 band_sel", 32'(band_sel), 32'h0);
      chk("R1 idle miso", 32'(miso), 32'h0);

      // R2: full write from register 0 plus one byte past register 9
      addr_match = 1'b1; data_ready = 1'b0;
      put(8'h00, st());
      put(8'h5A, 8'h00); put(8'hFF, 8'h00); put(8'hFF, 8'h00); put(8'h08, 8'h00);
      put(8'h3F, 8'h00); put(8'h11, 8'h00); put(8'h22, 8'h00); put(8'h33, 8'h00);
      put(8'h44, 8'h00); put(8'hDB, 8'h00); put(8'h77, 8'h00);
      spi_txn("R2");
      chk("R12 channel", 32'(channel), 32'h15A);
      chk("R12 pa_power", 32'(pa_power), 32'h3);
      chk("R12 band_sel", 32'(band_sel), 32'h1);

      // R3, R5: read all back, masked bits read as zero, 0x00 past register 9
      addr_match = 1'b0; data_ready = 1'b1;
      put(8'h10, st());
      put(8'h00, 8'h5A); put(8'h00, 8'h3F); put(8'h00, 8'h77); put(8'h00, 8'h08);
      put(8'h00, 8'h3F); put(8'h00, 8'h11); put(8'h00, 8'h22); put(8'h00, 8'h33);
      put(8'h00, 8'h44); put(8'h00, 8'hDB); put(8'h00, 8'h00);
      spi_txn("R5");

      // R3: read starting mid-map
      addr_match = 1'b1; data_ready = 1'b1;
      put(8'h17, st());
      put(8'h00, 8'h33); put(8'h00, 8'h44); put(8'h00, 8'hDB); put(8'h00, 8'h00);
      spi_txn("R3");

      // R2: write starting mid-map, then read it back
      put(8'h05, st()); put(8'hA1, 8'h00);
      spi_txn("R2");
      put(8'h15, st()); put(8'h00, 8'hA1);
      spi_txn("R2");

      // R4: start address above 9 is rejected for write and read
      addr_match = 1'b0; data_ready = 1'b0;
      put(8'h0C, st()); put(8'h99, 8'h00);
      spi_txn("R4");
      put(8'h1A, st()); put(8'h00, 8'h00); put(8'h00, 8'h00);
      spi_txn("R4");
      put(8'h10, st()); put(8'h00, 8'h5A);
      spi_txn("R4");

      // R6: TX payload width 4, six writes wrap onto indexes 0 and 1
      put(8'h04, st()); put(8'h04, 8'h00);
      spi_txn("R6");
      put(8'h20, st());
      for (int i = 0; i < 6; i++) put(8'(8'h10 + i), 8'h00);
      spi_txn("R6");
      put(8'h21, st());
      put(8'h00, 8'h14); put(8'h00, 8'h15); put(8'h00, 8'h12); put(8'h00, 8'h13); put(8'h00, 8'h14);
      spi_txn("R6");

      // R6: width 0 means the full 32 entries
      put(8'h04, st()); put(8'h00, 8'h00);
      spi_txn("R6");
      put(8'h20, st());
      for (int i = 0; i < 33; i++) put(8'(8'h40 + i), 8'h00);
      spi_txn("R6");
      put(8'h21, st());
      for (int j = 0; j < 34; j++) put(8'h00, ((j % 32) == 0) ? 8'h60 : 8'(8'h40 + (j % 32)));
      spi_txn("R6");

      // R7: TX address wraps after four bytes
      put(8'h22, st());
      for (int i = 0; i < 5; i++) put(8'(8'hC0 + i), 8'h00);
      spi_txn("R7");
      put(8'h23, st());
      put(8'h00, 8'hC4); put(8'h00, 8'hC1); put(8'h00, 8'hC2); put(8'h00, 8'hC3); put(8'h00, 8'hC4);
      spi_txn("R7");

      // R8: RX payload via load port, width 3, with load-port traffic during the read
      for (int i = 0; i < 8; i++) rx_load(i, 8'(8'h90 + i));
      put(8'h03, st()); put(8'h03, 8'h00);
      spi_txn("R8");
      put(8'h24, st());
      put(8'h00, 8'h90); put(8'h00, 8'h91); put(8'h00, 8'h92); put(8'h00, 8'h90);
      hammer_stop = 1'b0;
      fork
         begin
            spi_txn("R8");
            hammer_stop = 1'b1;
         end
         begin
            while (!hammer_stop) begin
               @(negedge clk);
               rx_load_en   = 1'b1;
               rx_load_idx  = 5'd20;
               rx_load_data = 8'hE7;
            end
            @(negedge clk);
            rx_load_en = 1'b0;
         end
      join
      put(8'h03, st()); put(8'h15, 8'h00);
      spi_txn("R8");
      put(8'h24, st());
      for (int j = 0; j < 21; j++)
         put(8'h00, (j < 8) ? 8'(8'h90 + j) : ((j == 20) ? 8'hE7 : 8'h00));
      spi_txn("R8");

      // R9: channel config, applied only when chip select rises
      put(8'h8E, st()); put(8'h34, 8'h00);
      spi_txn("R9", 1'b1);
      chk("R9 channel held while selected", 32'(channel), 32'h15A);
      csn = 1'b1;
      repeat (8) @(negedge clk);
      chk("R9 channel", 32'(channel), 32'h034);
      chk("R9 pa_power", 32'(pa_power), 32'h3);
      chk("R9 band_sel", 32'(band_sel), 32'h1);
      put(8'h81, st());
      spi_txn("R9");
      chk("R9 no data byte", 32'(channel), 32'h034);
      put(8'h10, st()); put(8'h00, 8'h34); put(8'h00, 8'h3E);
      spi_txn("R9");

      // R10: unknown codes return zero and change nothing
      addr_match = 1'b1; data_ready = 1'b1;
      put(8'h25, st()); put(8'hFF, 8'h00); put(8'hFF, 8'h00); put(8'hFF, 8'h00);
      spi_txn("R10");
      put(8'h50, st()); put(8'hAA, 8'h00);
      spi_txn("R10");
      put(8'h10, st()); put(8'h00, 8'h34); put(8'h00, 8'h3E);
      spi_txn("R10");
      put(8'h23, st()); put(8'h00, 8'hC4);
      spi_txn("R10");
      chk("R10 channel", 32'(channel), 32'h034);

      // R11: clocks while deselected, then a partial byte, are both discarded
      for (int i = 0; i < 5; i++) begin
         mosi = 1'b1;
         half(); sck = 1'b1; half(); sck = 1'b0;
      end
      chk("R11 channel idle clocks", 32'(channel), 32'h034);
      @(negedge clk);
      csn = 1'b0;
      half();
      for (int b = 0; b < 3; b++) begin
         mosi = 1'b1;
         half(); sck = 1'b1; half(); sck = 1'b0;
      end
      half();
      csn = 1'b1;
      repeat (8) @(negedge clk);
      addr_match = 1'b0; data_ready = 1'b1;
      put(8'h10, st()); put(8'h00, 8'h34);
      spi_txn("R11");
      chk("R11 channel", 32'(channel), 32'h034);

      chk("R1 scoreboard drained", 32'(exp_q.size()), 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule